// File: doc/BRIEF.md
# Serial-Framed Parallel Bus Bridge

This block carries the byte traffic of a parallel bus controller over a simple asynchronous serial link. The link runs at one times the data clock, so every serial bit lasts exactly one clock period and nothing is oversampled. When the incoming line falls while the block is idle, it opens a frame. It takes in eight bits, least significant first, through a 16-bit chain. The chain is an 8-bit command register followed by an 8-bit data register.

While the new byte enters the command register, the old command byte moves into the data register. In the same bit times the old data byte leaves on the outgoing line, framed by a start bit and a stop bit. A separate command strobe lets the controller side place a parallel byte into the data register. One bit of the command register selects whether the data register drives the controller port.

Top module: `serial_bus_bridge`

## Requirements
- R1: While reset (active-low `rstN`) is asserted, `serOut` is high, `cmdByte` and `parOut` are zero, and `frameDone` and `parOutEn` are low.
- R2: A low level on `serIn` at a clock edge while no frame is open starts a frame. For the following bit time, `serOut` is low (the echoed start bit).
- R3: A frame has exactly eight shift edges, one per clock, and the first comes one clock after the start edge. `frameDone` is high for exactly one clock, right after the eighth shift. Low inputs inside a frame are taken as data and never restart it.
- R4: `serOut` is high in the bit time after the eighth echoed data bit (stop bit) and at all times while idle.
- R5: After a frame, `cmdByte` holds the received byte. The first data bit after the start bit ends up in bit 0.
- R6: After a frame, `parOut` (the data register) holds the value `cmdByte` had before that frame.
- R7: In the eight bit times after the echoed start bit, `serOut` carries the data register value from before the frame, bit 0 first.
- R8: A rising edge of `cmdStrobe`, sampled at clock edge k, copies `parIn` into the data register at edge k+1. A strobe held high makes no further copies.
- R9: When a parallel copy falls on a shift edge, the data register takes `parIn` and the command register still shifts.
- R10: `parOutEn` equals bit 0 of `cmdByte`, and 1 means the block drives `parOut` toward the controller.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Data clock, also the serial bit clock |
| rstN | input | 1 | Asynchronous reset, active low |
| serIn | input | 1 | Incoming serial line, idles high |
| serOut | output | 1 | Outgoing serial line, idles high |
| cmdStrobe | input | 1 | Command strobe that requests a parallel copy |
| parIn | input | 8 | Parallel byte from the controller |
| parOut | output | 8 | Data register contents toward the controller |
| parOutEn | output | 1 | Drive enable for `parOut`, taken from the command register |
| cmdByte | output | 8 | Command register contents |
| frameDone | output | 1 | One-clock pulse after the eighth shift |

## Verification
Suppose the start bit is sampled at edge E0. The echoed start bit shows on `serOut` after E0, and echoed data bit i shows after edge E(i+1). `frameDone`, the new `cmdByte` and the new `parOut` all appear after E8, and the stop level appears after E9. A strobe rise sampled at edge k shows on `parOut` after edge k+1. The bench drives every input and reads every output on the falling clock edge. It counts these edges exactly, so each check falls in the bit time its result is due. It also looks one bit time early for `frameDone` and for the parallel copy, to confirm that neither arrives too soon.

// File: rtl/ssb_pkg.sv
package ssb_pkg;
  // strobes from control to datapath, one per clock
  typedef struct packed {
    logic startDet;  // idle line seen low: open frame, send start bit
    logic shift;     // advance the command/data chain by one bit
    logic load;      // delayed parallel capture into the data register
  } ctrlStrobes_t;
endpackage

// File: rtl/ssb_ctrl.sv
module ssb_ctrl
  import ssb_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic         clk,
  input  logic         rstN,
  input  logic         serIn,
  input  logic         cmdStrobe,
  output ctrlStrobes_t strobes,
  output logic         active,
  output logic         frameDone
);
  localparam int CNT_W = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W - 1);

  logic [CNT_W-1:0] bitCnt;
  logic             strobeQ;
  logic             loadPulse;

  always_comb begin
    strobes.startDet = !active && !serIn;
    strobes.shift    = active;
    strobes.load     = loadPulse;
  end

  // frame sequencing: start flag, bit counter, terminal count
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      active    <= 1'b0;
      bitCnt    <= '0;
      frameDone <= 1'b0;
    end else begin
      frameDone <= 1'b0;
      if (strobes.startDet) begin
        active <= 1'b1;
        bitCnt <= '0;
      end else if (active) begin
        if (bitCnt == LAST) begin
          active    <= 1'b0;
          bitCnt    <= '0;
          frameDone <= 1'b1;
        end else begin
          bitCnt <= bitCnt + 1'b1;
        end
      end
    end
  end

  // strobe edge detect, then one clock of delay before the capture
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      strobeQ   <= 1'b0;
      loadPulse <= 1'b0;
    end else begin
      strobeQ   <= cmdStrobe;
      loadPulse <= cmdStrobe && !strobeQ;
    end
  end

  p_done_pulse_r3: assert property (@(posedge clk) disable iff (!rstN)
    frameDone |=> !frameDone);
  p_done_idle_r3: assert property (@(posedge clk) disable iff (!rstN)
    frameDone |-> !active);
  p_start_from_low_r2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(active) |-> !$past(serIn));
  p_load_single_r8: assert property (@(posedge clk) disable iff (!rstN)
    loadPulse |=> !loadPulse);
endmodule

// File: rtl/ssb_datapath.sv
module ssb_datapath
  import ssb_pkg::*;
#(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              serIn,
  input  ctrlStrobes_t      strobes,
  input  logic [DATA_W-1:0] parIn,
  output logic [DATA_W-1:0] cmdReg,
  output logic [DATA_W-1:0] dataReg,
  output logic              serOut
);
  // line driver: start bit, then data tail bits, otherwise high
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      serOut <= 1'b1;
    end else if (strobes.startDet) begin
      serOut <= 1'b0;
    end else if (strobes.shift) begin
      serOut <= dataReg[0];
    end else begin
      serOut <= 1'b1;
    end
  end

  // head of chain: command register, fed LSB first from the line
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      cmdReg <= '0;
    end else if (strobes.shift) begin
      cmdReg <= {serIn, cmdReg[DATA_W-1:1]};
    end
  end

  // tail of chain: data register, parallel capture wins over shift
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      dataReg <= '0;
    end else if (strobes.load) begin
      dataReg <= parIn;
    end else if (strobes.shift) begin
      dataReg <= {cmdReg[0], dataReg[DATA_W-1:1]};
    end
  end

  p_load_wins_r9: assert property (@(posedge clk) disable iff (!rstN)
    strobes.load |=> dataReg == $past(parIn));
  p_shift_in_r5: assert property (@(posedge clk) disable iff (!rstN)
    strobes.shift |=> cmdReg[DATA_W-1] == $past(serIn));
  p_idle_high_r4: assert property (@(posedge clk) disable iff (!rstN)
    (!strobes.shift && !strobes.startDet) |=> serOut);
endmodule

// File: rtl/serial_bus_bridge.sv
module serial_bus_bridge
  import ssb_pkg::*;
#(
  parameter int DATA_W  = 8,
  parameter int DIR_BIT = 0
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              serIn,
  output logic              serOut,
  input  logic              cmdStrobe,
  input  logic [DATA_W-1:0] parIn,
  output logic [DATA_W-1:0] parOut,
  output logic              parOutEn,
  output logic [DATA_W-1:0] cmdByte,
  output logic              frameDone
);
  ctrlStrobes_t strobes;
  logic         active;

  ssb_ctrl #(.DATA_W(DATA_W)) u_ctrl (
    .clk       (clk),
    .rstN      (rstN),
    .serIn     (serIn),
    .cmdStrobe (cmdStrobe),
    .strobes   (strobes),
    .active    (active),
    .frameDone (frameDone)
  );

  ssb_datapath #(.DATA_W(DATA_W)) u_dp (
    .clk     (clk),
    .rstN    (rstN),
    .serIn   (serIn),
    .strobes (strobes),
    .parIn   (parIn),
    .cmdReg  (cmdByte),
    .dataReg (parOut),
    .serOut  (serOut)
  );

  assign parOutEn = cmdByte[DIR_BIT];

  p_start_echo_r2: assert property (@(posedge clk) disable iff (!rstN)
    $rose(active) |-> !serOut);
endmodule

// File: tb/serial_bus_bridge_test.sv
module serial_bus_bridge_test;
  logic       clk = 1'b0;
  logic       rstN;
  logic       serIn;
  logic       serOut;
  logic       cmdStrobe;
  logic [7:0] parIn;
  logic [7:0] parOut;
  logic       parOutEn;
  logic [7:0] cmdByte;
  logic       frameDone;

  int testCount = 0;
  int failCount = 0;
  bit finished  = 0;

  localparam int NVEC = 6;
  localparam logic [7:0] VEC [NVEC] = '{8'hA5, 8'h00, 8'hFF, 8'h3C, 8'h81, 8'h5A};

  always #10 clk = ~clk;  // 50 MHz

  serial_bus_bridge uut (
    .clk(clk), .rstN(rstN), .serIn(serIn), .serOut(serOut),
    .cmdStrobe(cmdStrobe), .parIn(parIn), .parOut(parOut),
    .parOutEn(parOutEn), .cmdByte(cmdByte), .frameDone(frameDone)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    testCount++;
    if (act !== exp) begin
      failCount++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  // one frame, inputs driven and outputs read on falling edges
  task automatic sendFrame(input logic [7:0] b, input bit collide,
                           input logic [7:0] pval, output logic [7:0] echo);
    @(negedge clk) serIn = 1'b0;                     // start bit, sampled at E0
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      if (i == 0) chk("R2 start bit echo", {7'b0, serOut}, 8'h00);
      else echo[i-1] = serOut;
      if (i == 7) chk("R3 no early done", {7'b0, frameDone}, 8'h00);
      if (collide && i == 1) begin parIn = pval; cmdStrobe = 1'b1; end
      if (collide && i == 3) chk("R9 load beats shift", parOut, pval);
      serIn = b[i];
    end
    @(negedge clk);                                  // after E8
    echo[7] = serOut;
    chk("R3 done pulse", {7'b0, frameDone}, 8'h01);
    serIn = 1'b1;
    cmdStrobe = 1'b0;
    @(negedge clk);                                  // after E9
    chk("R4 stop bit", {7'b0, serOut}, 8'h01);
    chk("R3 done one clock", {7'b0, frameDone}, 8'h00);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!finished) begin
      failCount++;
      testCount++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("[TB] %0d tests run, %0d failed", testCount, failCount);
      $finish;
    end
  end

  initial begin
    logic [7:0] expCmd;
    logic [7:0] expData;
    logic [7:0] echo;

    rstN = 1'b0; serIn = 1'b1; cmdStrobe = 1'b0; parIn = 8'h00;
    repeat (3) @(negedge clk);
    chk("R1 serOut reset", {7'b0, serOut}, 8'h01);
    chk("R1 cmdByte reset", cmdByte, 8'h00);
    chk("R1 parOut reset", parOut, 8'h00);
    chk("R1 frameDone reset", {7'b0, frameDone}, 8'h00);
    chk("R1 parOutEn reset", {7'b0, parOutEn}, 8'h00);
    rstN = 1'b1;
    repeat (2) @(negedge clk);
    chk("R4 idle high", {7'b0, serOut}, 8'h01);

    expCmd = 8'h00; expData = 8'h00;
    for (int v = 0; v < NVEC; v++) begin
      sendFrame(VEC[v], 1'b0, 8'h00, echo);
      chk("R7 echo of data register", echo, expData);
      expData = expCmd;
      expCmd  = VEC[v];
      chk("R5 command byte", cmdByte, expCmd);
      chk("R6 cascade into data", parOut, expData);
      chk("R10 direction bit", {7'b0, parOutEn}, {7'b0, expCmd[0]});
      repeat (2) @(negedge clk);
    end

    // parallel capture timing and held strobe
    parIn = 8'hC3; cmdStrobe = 1'b1;                 // rise sampled at next edge k
    @(negedge clk);
    chk("R8 no capture at edge k", parOut, expData);
    @(negedge clk);
    chk("R8 capture at edge k+1", parOut, 8'hC3);
    parIn = 8'h12;
    repeat (3) @(negedge clk);
    chk("R8 held strobe no reload", parOut, 8'hC3);
    cmdStrobe = 1'b0;
    @(negedge clk);
    sendFrame(8'h44, 1'b0, 8'h00, echo);
    chk("R7 echo of captured byte", echo, 8'hC3);
    chk("R6 cascade after capture", parOut, expCmd);
    expCmd = 8'h44;
    chk("R10 direction bit low", {7'b0, parOutEn}, 8'h00);

    // capture landing on a shift edge
    repeat (2) @(negedge clk);
    sendFrame(8'h96, 1'b1, 8'h7E, echo);
    chk("R9 command still shifts", cmdByte, 8'h96);

    // restore a known data byte and echo it
    repeat (2) @(negedge clk);
    parIn = 8'h0F; cmdStrobe = 1'b1;
    repeat (2) @(negedge clk);
    cmdStrobe = 1'b0;
    @(negedge clk);
    sendFrame(8'h00, 1'b0, 8'h00, echo);
    chk("R7 echo after recapture", echo, 8'h0F);
    chk("R6 cascade of prior command", parOut, 8'h96);
    chk("R5 zero command byte", cmdByte, 8'h00);

    finished = 1;
    $display("[TB] %0d tests run, %0d failed", testCount, failCount);
    $finish;
  end
endmodule